// File: doc/BRIEF.md
# Shaped Envelope Generator

This block produces a 4-bit amplitude that moves over time in one of several shapes, for use as the level source of a tone voice whose amplitude is set to follow the envelope. A 16-bit step period sets the speed: each amplitude step lasts sixteen clock cycles times the period value. A 4-bit shape word picks the form of the ramp. Its bits select the starting direction, whether the ramp repeats, whether the direction flips on each repeat, and whether the level freezes once the first ramp is over.

A one-cycle restart pulse takes a snapshot of the period and the shape. It clears the step counter and the clock prescaler, and it starts a fresh first ramp. Inputs that change between restarts do nothing until the next restart, so a bus writer can update the period bytes one at a time without ever showing a half-written value. The output level is driven from registers only, so it has no combinational path from any input.

Top module: `env_shaped_gen`

## Requirements
- R1: After reset, `level` is 0 and stays 0 until the first cycle in which `restart` is high, whatever `period` and `shape` do.
- R2: After a restart, the level holds each value for exactly 16 × P clock cycles, where P is the period captured at that restart; P = 0 behaves as P = 1.
- R3: The first ramp has 16 steps. With shape bit 2 (attack) set, it rises 0,1,…,15. With the bit clear, it falls 15,14,…,0.
- R4: With shape bit 3 (continue) clear, the level becomes 0 at the end of the first ramp and stays 0 until the next restart, whatever the other shape bits are.
- R5: With continue set and shape bits 0 (hold) and 1 (alternate) both clear, the first ramp repeats in the same direction without end.
- R6: With continue and alternate set and hold clear, each new ramp runs in the direction opposite to the one before it.
- R7: With continue and hold set and alternate clear, the level freezes at the final value of the first ramp: 15 if attack is set, 0 if not.
- R8: With continue, hold and alternate all set, the level freezes at the value opposite to the final value of the first ramp: 0 if attack is set, 15 if not.
- R9: A restart, even in the middle of a ramp, makes `level` equal the first value of the new first ramp (0 if attack is set, 15 if not) in the next cycle. Step timing then counts from that clock edge.
- R10: `period` and `shape` are sampled only in a restart cycle. Later changes have no effect on `level` until the next restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Single-cycle pulse: capture period and shape, begin a new first ramp |
| period | input | 16 | Step period P; one step lasts 16 × P cycles |
| shape | input | 4 | Bit 3 continue, bit 2 attack, bit 1 alternate, bit 0 hold |
| level | output | 4 | Current envelope amplitude |

## Verification
If the prescaler runs wrong, a step edge lands early or late by at least one cycle. This shows as a level mismatch within one step period of the restart. If the step counter or the direction flag is wrong, the output breaks the expected ramp sequence, and an error in the end-of-ramp decision can only show at the 16th step boundary, roughly 256 × P cycles in. That is why every shape code runs for three full ramps. A shape register or period register that reloads outside a restart only shows up after the inputs change in mid-run, and the bench covers that case on purpose.

// File: rtl/env_pkg.sv
package env_pkg;

  typedef enum logic [1:0] {
    ENV_IDLE = 2'd0,
    ENV_RUN  = 2'd1,
    ENV_HOLD = 2'd2
  } env_mode_e;

  typedef struct packed {
    logic cont;
    logic att;
    logic alt;
    logic hold;
  } env_shape_t;

endpackage

// File: rtl/env_prescaler.sv
module env_prescaler #(
  parameter int PER_W    = 16,
  parameter int DIV_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PER_W-1:0] period_in,
  output logic             tick
);
  localparam int PRE_W = PER_W + DIV_LOG2;

  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] per_eff;
  logic [PRE_W-1:0] lim_m1;
  logic [PRE_W-1:0] cnt_q;

  // A zero period is treated as one.
  assign per_eff = (per_q == '0) ? PER_W'(1) : per_q;
  assign lim_m1  = {per_eff, {DIV_LOG2{1'b0}}} - PRE_W'(1);
  assign tick    = (cnt_q == lim_m1) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      per_q <= period_in;
      cnt_q <= '0;
    end else if (cnt_q == lim_m1) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/env_step_counter.sv
module env_step_counter #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  output logic [LVL_W-1:0] step,
  output logic             ramp_end
);
  logic [LVL_W-1:0] step_q;

  assign step     = step_q;
  assign ramp_end = tick && (step_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_q <= '0;
    else if (clear)  step_q <= '0;
    else if (tick)   step_q <= step_q + LVL_W'(1);
  end
endmodule

// File: rtl/env_shaper.sv
module env_shaper
  import env_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       shape_in,
  input  logic             ramp_end,
  input  logic [LVL_W-1:0] step,
  output logic [LVL_W-1:0] level
);
  env_mode_e        mode_q;
  env_shape_t       shp_q;
  logic             rise_q;
  logic [LVL_W-1:0] hold_q;
  env_shape_t       shp_new;
  logic [LVL_W-1:0] end_val;

  assign shp_new = env_shape_t'(shape_in);
  // The value the current ramp finishes on.
  assign end_val = rise_q ? '1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ENV_IDLE;
      shp_q  <= '0;
      rise_q <= 1'b0;
      hold_q <= '0;
    end else if (start) begin
      mode_q <= ENV_RUN;
      shp_q  <= shp_new;
      rise_q <= shp_new.att;
      hold_q <= '0;
    end else if (mode_q == ENV_RUN && ramp_end) begin
      if (!shp_q.cont) begin
        mode_q <= ENV_IDLE;
      end else if (shp_q.hold) begin
        mode_q <= ENV_HOLD;
        hold_q <= shp_q.alt ? ~end_val : end_val;
      end else if (shp_q.alt) begin
        rise_q <= ~rise_q;
      end
    end
  end

  always_comb begin
    unique case (mode_q)
      ENV_RUN:  level = rise_q ? step : ~step;
      ENV_HOLD: level = hold_q;
      default:  level = '0;
    endcase
  end
endmodule

// File: rtl/env_shaped_gen.sv
module env_shaped_gen #(
  parameter int PER_W    = 16,
  parameter int LVL_W    = 4,
  parameter int DIV_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  input  logic [3:0]       shape,
  output logic [LVL_W-1:0] level
);
  logic             step_tick;
  logic             ramp_end;
  logic [LVL_W-1:0] step;

  env_prescaler #(.PER_W(PER_W), .DIV_LOG2(DIV_LOG2)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (restart),
    .period_in (period),
    .tick      (step_tick)
  );

  env_step_counter #(.LVL_W(LVL_W)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (restart),
    .tick     (step_tick),
    .step     (step),
    .ramp_end (ramp_end)
  );

  env_shaper #(.LVL_W(LVL_W)) u_shp (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (restart),
    .shape_in (shape),
    .ramp_end (ramp_end),
    .step     (step),
    .level    (level)
  );
endmodule

// File: rtl/env_checker.sv
module env_checker #(
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic [3:0]       shape,
  input logic             tick,
  input logic [LVL_W-1:0] level
);
  logic       seen;
  logic [4:0] n_ticks;
  logic [3:0] shp_c;
  logic       done_first;

  assign done_first = n_ticks[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      n_ticks <= '0;
      shp_c   <= '0;
    end else if (restart) begin
      seen    <= 1'b1;
      n_ticks <= '0;
      shp_c   <= shape;
    end else if (tick && !done_first) begin
      n_ticks <= n_ticks + 5'd1;
    end
  end

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> level == '0);

  a_r9_restart_start: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> level == ($past(shape[2]) ? {LVL_W{1'b0}} : {LVL_W{1'b1}}));

  a_r2_steady_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(level));

  a_r4_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && done_first && !shp_c[3]) |-> level == '0);

  a_r7_hold_end: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && done_first && shp_c[3] && shp_c[0] && !shp_c[1])
      |-> level == (shp_c[2] ? {LVL_W{1'b1}} : {LVL_W{1'b0}}));

  a_r8_hold_opposite: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && done_first && shp_c[3] && shp_c[0] && shp_c[1])
      |-> level == (shp_c[2] ? {LVL_W{1'b0}} : {LVL_W{1'b1}}));
endmodule

bind env_shaped_gen env_checker #(.LVL_W(LVL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .restart (restart),
  .shape   (shape),
  .tick    (step_tick),
  .level   (level)
);

// File: tb/sim_env_shaped_gen.sv
module sim_env_shaped_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 60000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic [15:0] period = '0;
  logic [3:0]  shape = '0;
  logic [3:0]  level;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 1'b0;
  string phase = "R1";

  // Behavioural model state
  bit m_started = 1'b0;
  bit m_att, m_alt, m_hold, m_cont;
  int m_lim = 16;
  int m_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  env_shaped_gen u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .period  (period),
    .shape   (shape),
    .level   (level)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_started = 1'b0;
      m_cyc = 0;
    end else if (restart) begin
      m_started = 1'b1;
      m_cyc  = 0;
      m_cont = shape[3];
      m_att  = shape[2];
      m_alt  = shape[1];
      m_hold = shape[0];
      m_lim  = 16 * ((period == 0) ? 1 : int'(period));
    end else if (m_started) begin
      m_cyc++;
    end
  end

  function automatic int model_level(output string tag);
    int steps, ramp, pos;
    bit up;
    if (!m_started) begin tag = "R1"; return 0; end
    steps = m_cyc / m_lim;
    ramp  = steps / 16;
    pos   = steps % 16;
    if (ramp == 0) begin
      tag = (m_cyc == 0) ? "R9" : "R3";
      return m_att ? pos : 15 - pos;
    end
    if (!m_cont) begin tag = "R4"; return 0; end
    if (m_hold) begin
      tag = m_alt ? "R8" : "R7";
      return (m_att ^ m_alt) ? 15 : 0;
    end
    tag = m_alt ? "R6" : "R5";
    up = m_att ^ (m_alt && (ramp % 2 == 1));
    return up ? pos : 15 - pos;
  endfunction

  always @(negedge clk) begin
    string tag;
    int exp_lvl;
    if (rst_n && !finished) begin
      exp_lvl = model_level(tag);
      n_chk++;
      if (int'(level) != exp_lvl) begin
        n_bad++;
        $display("FAIL %s/%s t=%0t level=%0d expected=%0d", tag, phase, $time, level, exp_lvl);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      n_bad++;
      n_chk++;
      $display("FAIL watchdog (all requirements) level=%0d expected=completion", level);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input logic [3:0] s, input logic [15:0] p);
    @(negedge clk);
    shape = s;
    period = p;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  initial begin
    // Reset state, R1
    run(3);
    n_chk++;
    if (level !== 4'd0) begin
      n_bad++;
      $display("FAIL R1 reset level=%0d expected=0", level);
    end
    @(negedge clk);
    rst_n = 1'b1;
    run(20);
    // R1: inputs move without a restart, level stays 0
    shape = 4'hC;
    period = 16'd1;
    run(40);

    // All shape codes at P=1: R3..R8
    for (int s = 0; s < 16; s++) begin
      phase = "shape";
      kick(4'(s), 16'd1);
      run(16 * 16 * 3 + 20);
    end

    // R2: zero period behaves as one, larger periods stretch steps
    phase = "R2";
    kick(4'hE, 16'd0);
    run(600);
    kick(4'hA, 16'd3);
    run(16 * 3 * 16 * 2 + 40);

    // R10: changes after restart are ignored
    phase = "R10";
    kick(4'hC, 16'd2);
    run(100);
    shape = 4'h0;
    period = 16'd7;
    run(1100);

    // R9: restart in mid-ramp
    phase = "R9";
    kick(4'h8, 16'd1);
    run(300);
    kick(4'hD, 16'd1);
    run(600);
    kick(4'h9, 16'd2);
    run(37);
    kick(4'h3, 16'd1);
    run(400);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule